// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Trigger

This block picks the moment at which a quasi-resonant flyback controller begins its next on-time. After the power switch turns off, the drain ringing produces a train of valleys. An analog comparator watching the auxiliary winding reports each valley as a falling level. The block brings that level into the clock domain and counts the falling crossings. It then raises a one-cycle turn-on request when the count reaches the valley number that the lockout selector has chosen. The first crossings after turn-off come from leakage-inductance ringing, so they are masked by a blanking window.

When the ringing is damped so heavily that crossings stop arriving, an internal timeout acts in place of each missing valley, and switching carries on. While soft-start is active, the timeout is stretched. At start-up the reflected output voltage is small, and the longer timeout lets the transformer demagnetize fully before the switch turns on again.

All times are counted in clock cycles. Parameters set them, and the defaults assume a 100 MHz clock: a 3 us blanking window, a 5.9 us timeout and a 40 us soft-start timeout. The control pins are plain levels and pulses. There is no streaming interface, so no back-pressure applies.

Top module: `qr_valley_trigger`

## Requirements
- R1: After reset, turn_on_o is low, and no falling crossing on zc_i produces a request until drv_off_i has been seen.
- R2: The block counts a high-to-low change on zc_i as a valley. With the default two-stage synchronizer, a low level first sampled at clock edge k is counted at edge k+2.
- R3: A pulse on drv_off_i sampled at edge e0 clears the count and opens a blanking window. Valleys counted at edges up to and including e0+BLANK_CYC are ignored. Hunting starts at edge H = e0+BLANK_CYC.
- R4: While hunting, if TMO_CYC cycles pass without a counted event (counted from H or from the last event), a substitute valley is counted at that edge and the timeout restarts.
- R5: While ss_active_i is high, the timeout length is TMO_SS_CYC instead of TMO_CYC.
- R6: valley_sel_i encodes the target valley minus one: a value of 0 means the 1st valley and a value of 3 means the 4th. The request fires on event number valley_sel_i+1.
- R7: turn_on_o is high for exactly the one cycle that follows the edge of the deciding event. The block then stays disarmed, with no further requests, until the next drv_off_i.
- R8: A real valley and a timeout that fall on the same edge count as one event.
- R9: A drv_off_i that arrives while the block is armed restarts the blanking window and the count from that edge.
- R10: A rising change on zc_i, or a level held steady, is never counted as a valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_i | input | 1 | Asynchronous zero-crossing comparator level; low means below the threshold |
| drv_off_i | input | 1 | One-cycle pulse marking the end of the on-time |
| valley_sel_i | input | SEL_W | Target valley minus one, from the lockout selector |
| ss_active_i | input | 1 | High while soft-start is running |
| turn_on_o | output | 1 | One-cycle request to start the next on-time |

## Verification
The assertions assume three things about the inputs. drv_off_i is a single-cycle pulse. valley_sel_i and ss_active_i stay stable while the block is hunting. TMO_SS_CYC is at least TMO_CYC. The stimulus holds the selector and the soft-start flag constant for each trial and only changes them before it issues drv_off_i. Falling crossings are spaced at least four cycles apart, so every crossing passes the synchronizer as a separate edge. Some crossings fall inside the blanking window, and gaps that exceed the timeout force substitute valleys.

// File: rtl/qrv_pkg.sv
package qrv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BLANK = 2'd1,
    PH_HUNT  = 2'd2
  } phase_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/qrv_zc_sync.sv
module qrv_zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_i,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= zc_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sh_q[STAGES-1];
  end

  assign fall_o = last_q & ~sh_q[STAGES-1];

  // R2: a falling crossing yields one isolated event
  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/qrv_phase_timer.sv
module qrv_phase_timer
  import qrv_pkg::*;
#(
  parameter int BLANK_CYC  = 300,
  parameter int TMO_CYC    = 590,
  parameter int TMO_SS_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic evt_i,
  input  logic done_i,
  input  logic ss_i,
  output logic hunt_o,
  output logic timeout_o
);
  localparam int MAX_T = max3(BLANK_CYC, TMO_CYC, TMO_SS_CYC);
  localparam int TMR_W = $clog2(MAX_T + 1);
  localparam logic [TMR_W-1:0] BLANK_M1 = TMR_W'(BLANK_CYC - 1);
  localparam logic [TMR_W-1:0] TMO_M1   = TMR_W'(TMO_CYC - 1);
  localparam logic [TMR_W-1:0] TMOSS_M1 = TMR_W'(TMO_SS_CYC - 1);

  phase_e           ph_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] lim_m1;

  always_comb lim_m1 = ss_i ? TMOSS_M1 : TMO_M1;

  assign hunt_o    = (ph_q == PH_HUNT);
  assign timeout_o = hunt_o && (tmr_q >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
    end else if (restart_i) begin
      ph_q  <= PH_BLANK;
      tmr_q <= '0;
    end else begin
      case (ph_q)
        PH_BLANK: begin
          if (tmr_q >= BLANK_M1) begin
            ph_q  <= PH_HUNT;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        PH_HUNT: begin
          if (done_i) begin
            ph_q  <= PH_IDLE;
            tmr_q <= '0;
          end else if (evt_i) begin
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          tmr_q <= '0;
        end
      endcase
    end
  end

  // R3: blanking never outlasts its window
  a_r3_blank_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_BLANK) |-> (tmr_q < TMR_W'(BLANK_CYC)));
  // R4: the hunting timer is always restarted by the event logic
  a_r4_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HUNT) |-> (tmr_q < TMR_W'(MAX_T)));
  // R4: a timeout in hunting is answered by a counted event
  a_r4_timeout_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !restart_i) |=> (tmr_q == '0));
endmodule

// File: rtl/qrv_valley_count.sv
module qrv_valley_count #(
  parameter int MAX_VALLEY = 4,
  parameter int SEL_W      = $clog2(MAX_VALLEY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             hunt_i,
  input  logic             fall_i,
  input  logic             timeout_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o,
  output logic             done_o,
  output logic             turn_on_o
);
  logic [SEL_W-1:0] cnt_q;
  logic             pulse_q;

  // R8: valley and timeout merge into one event
  assign evt_o     = hunt_i & (fall_i | timeout_i);
  assign done_o    = evt_o & (cnt_q >= sel_i);
  assign turn_on_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= done_o;
      if (done_o)     cnt_q <= '0;
      else if (evt_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: the request lasts a single cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |=> !turn_on_o);
  // R6: reaching the selected count fires the request next cycle
  a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> turn_on_o);
  // R6: the count never passes the selected valley
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_i |-> (cnt_q <= sel_i));
endmodule

// File: rtl/qr_valley_trigger.sv
module qr_valley_trigger #(
  parameter int BLANK_CYC   = 300,
  parameter int TMO_CYC     = 590,
  parameter int TMO_SS_CYC  = 4000,
  parameter int MAX_VALLEY  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(MAX_VALLEY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_i,
  input  logic             drv_off_i,
  input  logic [SEL_W-1:0] valley_sel_i,
  input  logic             ss_active_i,
  output logic             turn_on_o
);
  logic fall_w;
  logic hunt_w;
  logic timeout_w;
  logic evt_w;
  logic done_w;

  qrv_zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .zc_i   (zc_i),
    .fall_o (fall_w)
  );

  qrv_phase_timer #(
    .BLANK_CYC  (BLANK_CYC),
    .TMO_CYC    (TMO_CYC),
    .TMO_SS_CYC (TMO_SS_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (drv_off_i),
    .evt_i     (evt_w),
    .done_i    (done_w),
    .ss_i      (ss_active_i),
    .hunt_o    (hunt_w),
    .timeout_o (timeout_w)
  );

  qrv_valley_count #(
    .MAX_VALLEY (MAX_VALLEY),
    .SEL_W      (SEL_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (drv_off_i),
    .hunt_i    (hunt_w),
    .fall_i    (fall_w),
    .timeout_i (timeout_w),
    .sel_i     (valley_sel_i),
    .evt_o     (evt_w),
    .done_o    (done_w),
    .turn_on_o (turn_on_o)
  );

  // R7: once the request is issued the block has left hunting
  a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |-> !hunt_w);
  // R1: no request is raised straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !turn_on_o);
endmodule

// File: tb/qr_valley_trigger_bench.sv
module qr_valley_trigger_bench;
  localparam int BLANK  = 20;
  localparam int TMO    = 40;
  localparam int TMO_SS = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zc_i = 1'b1;
  logic       drv_off_i = 1'b0;
  logic [1:0] valley_sel_i = 2'd0;
  logic       ss_active_i = 1'b0;
  logic       turn_on_o;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  int  offs[8];
  int  nfall = 0;

  qr_valley_trigger #(
    .BLANK_CYC(BLANK), .TMO_CYC(TMO), .TMO_SS_CYC(TMO_SS)
  ) u_qr_valley_trigger (
    .clk(clk), .rst_n(rst_n), .zc_i(zc_i), .drv_off_i(drv_off_i),
    .valley_sel_i(valley_sel_i), .ss_active_i(ss_active_i),
    .turn_on_o(turn_on_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Expected edge of the deciding event, from R3, R4, R5, R6 and R8
  function automatic int predict(int e0, int sel, bit ss);
    int last = e0 + BLANK;
    int lim  = ss ? TMO_SS : TMO;
    for (int k = 0; k <= sel; k++) begin
      int best = last + lim;
      for (int i = 0; i < nfall; i++) begin
        int f = e0 + offs[i];
        if (f > last && f < best) best = f;
      end
      last = best;
    end
    return last;
  endfunction

  // Issue drv_off, play the scheduled crossings, and check the turn-on edge.
  // rise_off > 0: zc held low at the start and raised at that offset (R10).
  task automatic run_case(int sel, bit ss, int rise_off, string req);
    int e0, exp, got, np;
    @(negedge clk);
    valley_sel_i = 2'(sel);
    ss_active_i  = ss;
    zc_i         = (rise_off > 0) ? 1'b0 : 1'b1;
    drv_off_i    = 1'b1;
    e0  = cyc + 1;
    exp = predict(e0, sel, ss);
    got = -1;
    np  = 0;
    @(negedge clk);
    drv_off_i = 1'b0;
    while (cyc < exp + 8) begin
      for (int i = 0; i < nfall; i++) begin
        if (cyc + 3 == e0 + offs[i]) zc_i = 1'b0;
        if (cyc + 1 == e0 + offs[i]) zc_i = 1'b1;
      end
      if (rise_off > 0 && cyc == e0 + rise_off) zc_i = 1'b1;
      if (turn_on_o) begin
        np++;
        if (np == 1) got = cyc;
      end
      @(negedge clk);
    end
    chk(np == 1 && got == exp, req, got, exp);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1379);
    // R1: quiet through and after reset, zc toggling
    repeat (3) @(negedge clk);
    chk(turn_on_o == 1'b0, "R1 reset", int'(turn_on_o), 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        zc_i = (i % 6) < 3;
        if (turn_on_o) seen++;
      end
      chk(seen == 0, "R1 no request before drv_off", seen, 0);
    end

    // R4/R6: pure timeouts for every selector value
    nfall = 0;
    for (int s = 0; s < 4; s++) run_case(s, 1'b0, 0, "R4 R6 timeout-only");
    // R5: soft-start stretches the timeout
    run_case(3, 1'b1, 0, "R5 soft-start timeout");
    run_case(0, 1'b1, 0, "R5 soft-start single");

    // R2/R6: real valleys, 4th selected
    nfall = 4;
    offs[0] = BLANK + 5; offs[1] = BLANK + 10;
    offs[2] = BLANK + 15; offs[3] = BLANK + 20;
    run_case(3, 1'b0, 0, "R2 R6 four valleys");
    run_case(1, 1'b0, 0, "R6 second valley");

    // R3: crossings inside the blanking window, one on the last blanked edge
    nfall = 3;
    offs[0] = 5; offs[1] = 12; offs[2] = BLANK;
    run_case(0, 1'b0, 0, "R3 blanked valleys");

    // R8: valley on the same edge as the timeout counts once
    nfall = 1;
    offs[0] = BLANK + TMO;
    run_case(1, 1'b0, 0, "R8 coincident valley");

    // R10: rising edge only
    nfall = 0;
    run_case(0, 1'b0, BLANK + 10, "R10 rising ignored");

    // R7: disarmed after a request, crossings produce nothing
    begin
      int seen = 0;
      for (int i = 0; i < 3 * TMO; i++) begin
        @(negedge clk);
        zc_i = (i % 8) < 4;
        if (turn_on_o) seen++;
      end
      chk(seen == 0, "R7 disarmed", seen, 0);
    end

    // R9: restart while armed (first drv_off, then run_case issues another)
    nfall = 0;
    @(negedge clk); drv_off_i = 1'b1;
    @(negedge clk); drv_off_i = 1'b0;
    repeat (BLANK + 10) @(negedge clk);
    run_case(2, 1'b0, 0, "R9 restart");

    // Random trials
    for (int t = 0; t < 40; t++) begin
      int sel, lim, o;
      bit ss;
      sel = int'($urandom % 4);
      ss  = ($urandom % 4) == 0;
      lim = ss ? TMO_SS : TMO;
      nfall = int'($urandom % 7);
      o = 3 + int'($urandom % (BLANK + 10));
      for (int i = 0; i < nfall; i++) begin
        offs[i] = o;
        o = o + 4 + int'($urandom % (lim + lim / 2));
      end
      run_case(sel, ss, 0, "R2 R3 R4 R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule